// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache with Tree Pseudo-LRU Replacement

This block is a read-only cache that sits between a requester and a slower word memory. A request address is cut into three fields. The high field is the tag. The middle field picks one set. The low bits select a byte within the word and do not take part in the lookup. The four ways of the chosen set are compared at the same time, and a 4-to-1 multiplexer returns the word from the way that matched. A hit answers one cycle after the request is accepted.

On a miss the block stops accepting requests. It issues a word-aligned fetch and holds it until memory acknowledges. It then writes the returned word into the set and passes the same word to the requester. If the set has an empty way, the lowest-numbered empty way takes the word. If the set is full, a three-bit binary-tree pseudo-LRU state chooses the victim. Each hit and each fill steers the two tree bits on the path of the way just used so that they point away from it.

Top module: `cache4_plru`

## Requirements
- R1: The address is split as byte offset = bits [OFF_W-1:0], set index = bits [OFF_W+IDX_W-1:OFF_W], tag = the remaining upper bits. The defaults are a 2-bit offset, 8-bit index and 22-bit tag. Offset bits never change hit/miss or data, and `mem_addr` always has its offset bits at zero.
- R2: After reset every way is invalid, so the first access to any set misses. After reset `ready`=1, `resp_valid`=0 and `mem_req`=0.
- R3: A request accepted (`req_valid` with `ready`) that hits gives `resp_valid`=1 with the stored word on the next cycle. It raises no `mem_req`.
- R4: An accepted request that misses raises `mem_req` on the next cycle, with `ready` low. It holds `mem_req` and a stable `mem_addr` until `mem_ack`. On the cycle after `mem_ack`, `resp_valid`=1 with the `mem_data` sampled at the ack, and `ready` returns to 1.
- R5: On a fill into a set that has an invalid way, the lowest-numbered invalid way is written.
- R6: On a fill into a full set, the victim is chosen from three per-set bits B1, B2 and B3. If B1=0 the victim is way B2 (way 0 or 1). If B1=1 the victim is way 2+B3.
- R7: Every hit and every fill on way w updates the tree. For w in {0,1}: B1←1 and B2←~w[0]. For w in {2,3}: B1←0 and B3←~w[0]. All bits reset to 0.
- R8: At most one way of a set hits at any time.
- R9: The way most recently accessed in a set is never the next victim of that set.
- R10: `req_valid` while `ready` is low is ignored. It does not change `mem_addr`, and the request is not served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Byte address of the read |
| ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | Read word is valid |
| resp_data | output | DATA_W | Read word |
| mem_req | output | 1 | Fetch request to memory, held until ack |
| mem_addr | output | ADDR_W | Word-aligned fetch address |
| mem_ack | input | 1 | Memory returns the word this cycle |
| mem_data | input | DATA_W | Word from memory |

## Verification
The assertions assume that memory acknowledges only while `mem_req` is high. They also assume that two ways never hold the same tag in a set, which the fill path guarantees as long as fills happen only after a miss. The bench raises `mem_ack` only during a pending fetch, after a varying delay. It drives requests only at idle, except for deliberate requests during a fetch that test R10. It uses a 4-set configuration and six competing tags, so every set sees empty-way fills, pseudo-LRU evictions and hits on each way.

// File: rtl/cache4_pkg.sv
package cache4_pkg;

    localparam int NWAYS = 4;
    localparam int WAY_W = 2;

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [NWAYS-1:0] wayvec_t;

    // root: pair select, lo: within ways 0/1, hi: within ways 2/3
    typedef struct packed {
        logic hi;
        logic lo;
        logic root;
    } plru_t;

    typedef enum logic {ST_IDLE, ST_FILL} state_t;

    function automatic way_t plru_victim(plru_t p);
        if (!p.root) return {1'b0, p.lo};
        return {1'b1, p.hi};
    endfunction

    function automatic plru_t plru_touch(plru_t p, way_t w);
        plru_t n;
        n = p;
        if (!w[1]) begin
            n.root = 1'b1;
            n.lo   = ~w[0];
        end else begin
            n.root = 1'b0;
            n.hi   = ~w[0];
        end
        return n;
    endfunction

    function automatic way_t lowest_free(wayvec_t v);
        way_t r;
        r = '0;
        for (int i = NWAYS - 1; i >= 0; i--)
            if (!v[i]) r = way_t'(i);
        return r;
    endfunction

    function automatic way_t hot_index(wayvec_t h);
        way_t r;
        r = '0;
        for (int i = 0; i < NWAYS; i++)
            if (h[i]) r = way_t'(i);
        return r;
    endfunction

endpackage

// File: rtl/cache4_way.sv
module cache4_way #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_data  = data_mem[rd_idx];
endmodule

// File: rtl/cache4_match.sv
module cache4_match
    import cache4_pkg::*;
#(
    parameter int TAG_W = 22
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TAG_W-1:0]   look_tag,
    input  logic [TAG_W-1:0]   way_tag [NWAYS],
    input  wayvec_t            way_valid,
    output wayvec_t            hit_vec
);
    for (genvar g = 0; g < NWAYS; g++) begin : g_cmp
        assign hit_vec[g] = way_valid[g] && (way_tag[g] == look_tag);
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R8
endmodule

// File: rtl/cache4_tree.sv
module cache4_tree
    import cache4_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output plru_t            rd_bits,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  way_t             upd_way
);
    localparam int SETS = 1 << IDX_W;

    plru_t bits_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
        end else if (upd_en) begin
            bits_q[upd_idx] <= plru_touch(bits_q[upd_idx], upd_way);
        end
    end

    assign rd_bits = bits_q[rd_idx];

    AST_MRU_SPARED: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> plru_victim(bits_q[$past(upd_idx)]) != $past(upd_way)); // R9
endmodule

// File: rtl/cache4_plru.sv
module cache4_plru
    import cache4_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    state_t            state_q;
    logic [TAG_W-1:0]  q_tag;
    logic [IDX_W-1:0]  q_idx;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;

    logic [IDX_W-1:0]  in_idx, look_idx;
    logic [TAG_W-1:0]  in_tag, look_tag;
    logic [TAG_W-1:0]  way_tag  [NWAYS];
    logic [DATA_W-1:0] way_data [NWAYS];
    wayvec_t           way_valid, hit_vec, way_we;
    way_t              hit_way, victim;
    plru_t             tree_bits;
    logic              accept, fill, any_hit;

    assign in_idx   = req_addr[OFF_W +: IDX_W];
    assign in_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign look_idx = (state_q == ST_IDLE) ? in_idx : q_idx;
    assign look_tag = (state_q == ST_IDLE) ? in_tag : q_tag;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign fill    = (state_q == ST_FILL) && mem_ack;
    assign any_hit = |hit_vec;
    assign hit_way = hot_index(hit_vec);
    assign victim  = (&way_valid) ? plru_victim(tree_bits) : lowest_free(way_valid);

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        assign way_we[g] = fill && (victim == way_t'(g));
        cache4_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (look_idx),
            .rd_valid (way_valid[g]),
            .rd_tag   (way_tag[g]),
            .rd_data  (way_data[g]),
            .we       (way_we[g]),
            .wr_idx   (q_idx),
            .wr_tag   (q_tag),
            .wr_data  (mem_data)
        );
    end

    cache4_match #(.TAG_W(TAG_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .look_tag  (look_tag),
        .way_tag   (way_tag),
        .way_valid (way_valid),
        .hit_vec   (hit_vec)
    );

    cache4_tree #(.IDX_W(IDX_W)) u_tree (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (look_idx),
        .rd_bits (tree_bits),
        .upd_en  ((accept && any_hit) || fill),
        .upd_idx (look_idx),
        .upd_way (fill ? victim : hit_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            q_tag        <= '0;
            q_idx        <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    if (any_hit) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= way_data[hit_way];
                    end else begin
                        state_q <= ST_FILL;
                        q_tag   <= in_tag;
                        q_idx   <= in_idx;
                    end
                end
                ST_FILL: if (mem_ack) begin
                    resp_valid_q <= 1'b1;
                    resp_data_q  <= mem_data;
                    state_q      <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready      = (state_q == ST_IDLE);
    assign mem_req    = (state_q == ST_FILL);
    assign mem_addr   = {q_tag, q_idx, {OFF_W{1'b0}}};
    assign resp_valid = resp_valid_q;
    assign resp_data  = resp_data_q;

    AST_HIT_FAST: assert property (@(posedge clk) disable iff (rst)
        accept && any_hit |=> resp_valid && !mem_req); // R3
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R4
    AST_FILL_ANSWER: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> resp_valid && ready && (resp_data == $past(mem_data))); // R4
    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        fill && !(&way_valid) |-> $onehot(way_we & ~way_valid)); // R5
    AST_MISS_FETCH: assert property (@(posedge clk) disable iff (rst)
        accept && !any_hit |=> mem_req && !ready); // R4
endmodule

// File: tb/sim_cache4_plru.sv
module sim_cache4_plru;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 2;
    localparam int SETS  = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        ready, resp_valid, mem_req;
    logic [31:0] resp_data, mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_data = '0;

    int checks = 0;
    int fails  = 0;

    // bench model of tags, valid bits and tree bits
    logic [27:0] m_tag [SETS][4];
    logic        m_val [SETS][4];
    logic        m_b1 [SETS], m_b2 [SETS], m_b3 [SETS];

    always #(CLK_PERIOD/2) clk = ~clk;

    cache4_plru #(.ADDR_W(32), .IDX_W(IDX_W), .OFF_W(2), .DATA_W(32)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .ready(ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data)
    );

    function automatic logic [31:0] word_of(logic [31:0] a);
        return {a[31:2], 2'b00} * 32'h9E37_79B1 + 32'h1234_5678;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic touch(input int s, input int w);
        if (w < 2) begin m_b1[s] = 1'b1; m_b2[s] = (w == 0); end
        else       begin m_b1[s] = 1'b0; m_b3[s] = (w == 2); end
    endtask

    task automatic access(input logic [31:0] a, input int dly);
        int s, hw, v;
        logic [27:0] t;
        logic full;
        string lbl;
        s = int'(a[3:2]);
        t = a[31:4];
        hw = -1;
        full = 1'b1;
        for (int w = 0; w < 4; w++) begin
            if (m_val[s][w] && m_tag[s][w] == t) hw = w;
            if (!m_val[s][w]) full = 1'b0;
        end
        @(negedge clk);
        check("R10 ready at idle", {31'b0, ready}, 32'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (hw >= 0) begin
            check("R3 hit valid", {30'b0, resp_valid, mem_req}, 32'd2);
            check("R1/R3 hit data", resp_data, word_of(a));
            touch(s, hw);
        end else begin
            lbl = (!m_val[s][0] && !m_val[s][1] && !m_val[s][2] && !m_val[s][3]) ? "R2 miss" : "R4 miss";
            check(lbl, {30'b0, mem_req, ready}, 32'd2);
            check("R1 fetch addr", mem_addr, {a[31:2], 2'b00});
            for (int k = 0; k < dly; k++) begin
                req_valid = 1'b1;               // R10: ignored while busy
                req_addr  = a ^ 32'h0000_1230;
                @(negedge clk);
                check("R4/R10 fetch held", {31'b0, mem_req}, 32'd1);
                check("R10 addr stable", mem_addr, {a[31:2], 2'b00});
            end
            req_valid = 1'b0;
            mem_ack  = 1'b1;
            mem_data = word_of(a);
            @(negedge clk);
            mem_ack = 1'b0;
            check("R4 fill resp", {30'b0, resp_valid, ready}, 32'd3);
            check("R4 fill data", resp_data, word_of(a));
            if (!full) begin
                v = 3;
                for (int w = 3; w >= 0; w--) if (!m_val[s][w]) v = w;   // R5
            end else begin
                v = m_b1[s] ? (2 + int'(m_b3[s])) : int'(m_b2[s]);      // R6
            end
            m_val[s][v] = 1'b1;
            m_tag[s][v] = t;
            touch(s, v);                                                // R7
        end
    endtask

    initial begin
        logic [31:0] lcg;
        for (int s = 0; s < SETS; s++) begin
            m_b1[s] = 0; m_b2[s] = 0; m_b3[s] = 0;
            for (int w = 0; w < 4; w++) begin m_val[s][w] = 0; m_tag[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 reset outputs", {29'b0, ready, resp_valid, mem_req}, 32'd4);

        // R5: fill every way of every set, then hit each with other offsets (R1)
        for (int s = 0; s < SETS; s++)
            for (int t = 1; t <= 4; t++) access({t[27:0], s[1:0], 2'b00}, t % 3);
        for (int s = 0; s < SETS; s++)
            for (int t = 1; t <= 4; t++) access({t[27:0], s[1:0], t[1:0]}, 0);

        // R6/R7/R9 directed: touch tag 1 in set 0, evict, tag 1 must survive
        access({28'd1, 2'd0, 2'd0}, 0);
        access({28'd9, 2'd0, 2'd0}, 1);
        access({28'd1, 2'd0, 2'd3}, 0);
        check("R9 MRU kept", {31'b0, m_val[0][0] && m_tag[0][0] == 28'd1}, 32'd1);

        // sweep: six competing tags over all sets, mixed offsets and ack delays
        lcg = 32'h2468_ACE1;
        for (int n = 0; n < 800; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            access({25'd0, 3'(lcg[18:16] % 6), lcg[21:20], lcg[25:24]}, int'(lcg[29:28]) % 3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule